// File: doc/BRIEF.md
# DDR Burst Column Sequencer

This block turns one column access into the sequence of column addresses a DDR device walks through during a burst. A single-cycle start pulse captures the start column, the 3-bit burst-length code and the burst-type bit. From the next cycle the block presents one column address per cycle, with a valid flag, until the burst is complete. The final beat carries a last flag.

Only the three least significant column bits take part in the ordering. The burst length sets a window of 2, 4 or 8 columns. Inside that window, sequential order counts upward from the start column and wraps at the window edge. Interleaved order XORs the beat index into the start offset. Column bits above the window come from the start column unchanged.

A terminate input cuts a burst short. A burst-length code that names no supported length produces an error pulse and no beats.

Top module: `ddr_burst_colgen`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `beat_valid`, `beat_last` and `bad_len` are all 0.
- R2: A `start` accepted while idle with `bl_code` equal to 1, 2 or 3 produces exactly 2, 4 or 8 beats. The burst length is 1 shifted left by `bl_code`. The beats come on consecutive cycles, beginning in the cycle after the start, with `beat_valid` high on each.
- R3: With `interleave` = 0 at start (sequential order), the window bits of beat i equal (start offset + i) modulo the burst length.
- R4: With `interleave` = 1 at start (interleaved order), the window bits of beat i equal the start offset XOR i.
- R5: The window is the low log2(length) column bits, and the start offset is the start column taken within that window. Every other column bit of every beat equals the start column. This covers the bits of [2:0] that lie above the window and all bits from bit 3 upward.
- R6: `beat_last` is high on the final beat of a burst, and at no other time.
- R7: A `start` that arrives while a burst is in progress is ignored. The burst continues unchanged, and no further beats follow it.
- R8: A `start` accepted while idle with `bl_code` equal to 0 or 4 to 7 produces no beats. It raises `bad_len` for exactly the one cycle after the start.
- R9: If `terminate` is high during a beat, that beat is the last one output, and `beat_valid` is 0 in the next cycle.
- R10: `start_col`, `bl_code` and `interleave` are captured at start. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a burst |
| start_col | input | COL_W | Start column address |
| bl_code | input | 3 | Burst-length code; length = 1 << code; valid codes are 1, 2, 3 |
| interleave | input | 1 | Burst type: 0 = sequential, 1 = interleaved |
| terminate | input | 1 | Ends the burst after the current beat |
| beat_valid | output | 1 | A column address is presented this cycle |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| bad_len | output | 1 | One-cycle pulse after a start with a reserved length code |

## Verification
The assertions assume that `start` and `terminate` are synchronous to `clk` and stable around the rising edge. They also assume reset is applied before any request.

The bench meets this by changing every input only on the falling edge and holding reset for several cycles first. The interleaved-order and wrap checks rely on `start_col` carrying arbitrary low bits. For that reason the stimulus table uses unaligned start columns and varied upper bits, so window alignment is never given for free.

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             terminate,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             bad_len
);

  localparam int ORD_W = 3;

  logic             busy;
  logic [ORD_W-1:0] idx;
  logic [ORD_W-1:0] span_m1;
  logic [COL_W-1:0] base;
  logic             ilv;

  wire             code_ok = (bl_code != 3'd0) && (bl_code <= 3'd3);
  wire [ORD_W:0]   new_len = (ORD_W+1)'(1) << bl_code[1:0];
  wire [ORD_W-1:0] ord     = ilv ? (base[ORD_W-1:0] ^ idx) : (base[ORD_W-1:0] + idx);
  wire [ORD_W-1:0] lo      = (base[ORD_W-1:0] & ~span_m1) | (ord & span_m1);

  assign beat_valid = busy;
  assign beat_last  = busy && (idx == span_m1);
  assign beat_col   = {base[COL_W-1:ORD_W], lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      span_m1 <= '0;
      base    <= '0;
      ilv     <= 1'b0;
      bad_len <= 1'b0;
    end else begin
      bad_len <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (code_ok) begin
            busy    <= 1'b1;
            idx     <= '0;
            base    <= start_col;
            ilv     <= interleave;
            span_m1 <= ORD_W'(new_len - 1'b1);
          end else begin
            bad_len <= 1'b1;
          end
        end
      end else if (beat_last || terminate) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  p_last_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  p_idle_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !beat_valid);

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |-> $stable(beat_col[COL_W-1:ORD_W]));

  p_no_beats_on_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_len |-> !beat_valid);

  p_term_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && terminate) |=> !beat_valid);

  p_burst_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_valid) |-> $past(start));

endmodule

// File: tb/ddr_burst_colgen_tb.sv
module ddr_burst_colgen_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = 3'd0;
  logic             interleave = 1'b0;
  logic             terminate = 1'b0;
  logic             beat_valid, beat_last, bad_len;
  logic [COL_W-1:0] beat_col;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ddr_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .interleave(interleave), .terminate(terminate),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last),
    .bad_len(bad_len)
  );

  // {interleave, bl_code, start_col}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 3'd1, 10'd0},   {1'b0, 3'd1, 10'd1},
    {1'b1, 3'd1, 10'd3},   {1'b0, 3'd2, 10'd6},
    {1'b1, 3'd2, 10'd7},   {1'b0, 3'd2, 10'h2f9},
    {1'b0, 3'd3, 10'd5},   {1'b1, 3'd3, 10'd5},
    {1'b0, 3'd3, 10'h3ff}, {1'b1, 3'd3, 10'h156},
    {1'b1, 3'd2, 10'h20a}, {1'b0, 3'd3, 10'h0c0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_col(int col, int code, bit ilv, int i);
    int len = 1 << code;
    int off = col % len;
    int win = col - off;
    return ilv ? win + (off ^ i) : win + ((off + i) % len);
  endfunction

  // term_at < 0: no terminate; poke: start with other fields during beat 1
  task automatic burst(input int col, input int code, input bit ilv,
                       input int term_at, input bit poke);
    int len = 1 << code;
    int n = (term_at >= 0 && term_at < len) ? term_at + 1 : len;
    start = 1'b1; start_col = COL_W'(col); bl_code = 3'(code); interleave = ilv;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(beat_valid === 1'b1, "R2 valid", int'(beat_valid), 1);
      chk(beat_col === COL_W'(exp_col(col, code, ilv, i)),
          ilv ? "R4/R5 interleaved column" : "R3/R5 sequential column",
          int'(beat_col), exp_col(col, code, ilv, i));
      chk(beat_last === (i == len - 1), "R6 last flag", int'(beat_last), int'(i == len - 1));
      terminate = (i == term_at);
      if (poke) begin
        start = (i == 1);
        start_col = ~COL_W'(col);
        bl_code = 3'd1;
        interleave = ~ilv;
      end
      @(negedge clk);
      terminate = 1'b0;
      start = 1'b0;
    end
    chk(beat_valid === 1'b0, term_at >= 0 ? "R9 idle after terminate" : "R2 idle after burst",
        int'(beat_valid), 0);
    if (poke) begin
      @(negedge clk);
      chk(beat_valid === 1'b0, "R7 no burst from ignored start", int'(beat_valid), 0);
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(beat_valid === 1'b0 && beat_last === 1'b0 && bad_len === 1'b0,
        "R1 reset outputs", int'({beat_valid, beat_last, bad_len}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat_valid === 1'b0 && bad_len === 1'b0, "R1 after release",
        int'({beat_valid, bad_len}), 0);

    for (int v = 0; v < NV; v++)
      burst(int'(VEC[v][9:0]), int'(VEC[v][12:10]), VEC[v][13], -1, 1'b0);

    // R7, R10: start and field changes mid-burst
    burst(10'h1a3, 3, 1'b0, -1, 1'b1);
    burst(10'h0b6, 2, 1'b1, -1, 1'b1);

    // R9: terminate part-way and on the first beat
    burst(10'h04d, 3, 1'b1, 2, 1'b0);
    burst(10'h211, 2, 1'b0, 0, 1'b0);

    // R8: reserved codes
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 3) continue;
      start = 1'b1; bl_code = 3'(c); start_col = 10'h155;
      @(negedge clk);
      start = 1'b0;
      chk(bad_len === 1'b1, "R8 error pulse", int'(bad_len), 1);
      chk(beat_valid === 1'b0, "R8 no beats", int'(beat_valid), 0);
      @(negedge clk);
      chk(bad_len === 1'b0 && beat_valid === 1'b0, "R8 pulse one cycle",
          int'({bad_len, beat_valid}), 0);
    end

    burst(10'h3fe, 1, 1'b1, -1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule